// File: doc/BRIEF.md
# Serial Command Front End with Chained Shift-Out and Deferred Readback

This block takes a 24-bit serial command stream, clocked by an external serial clock and framed by an active-low chip select, and turns it into one command event for a two-channel wiper-setting executor. The serial clock, chip select and data input are brought into the system clock domain through synchronisers. Data is taken on each rising serial clock edge while chip select is low. Nothing is issued until chip select goes high again. Only a frame of exactly 24 clocks produces a command. The command, address and data fields are then handed over, together with a single-cycle valid strobe in the system clock domain.

The same 24-bit shift register also feeds the serial output. As each new bit shifts in, the bit clocked in 24 clocks earlier shifts out, so several devices can be chained on one select line. When a readback command (code 9 or 10) is issued, the executor returns the selected 10-bit register value in the strobe cycle. The block writes that value into the low data bits, so the next full frame shifts it out. The output is open-drain style: a data bit plus an enable. The enable is active only in the frame that follows a readback.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, cmd_valid_o, sdo_oe_o and sdo_o are all 0, and the shift register holds all zeros.
- R2: A bit is shifted in from sdi_i on each rising edge of sclk_i only while csn_i is low. Serial clock edges while csn_i is high leave the register unchanged.
- R3: When csn_i rises after exactly 24 serial clocks, cmd_valid_o is high for exactly one system clock cycle. That cycle is the third system clock cycle after the rise. With it, cmd_o carries frame bits 23:20, addr_o bits 19:16 and data_o bits 15:0. The first bit shifted in is bit 23.
- R4: A frame of any length other than 24 clocks (for example 23 or 25) produces no cmd_valid_o pulse.
- R5: sdo_o presents the register MSB. Before each rising serial clock of a frame it shows the previous 24-bit content, MSB first. That content is the last 24 bits clocked in, including bits from frames that were discarded.
- R6: For command code 9 or 10, register bits 15:0 are replaced by rb_data_i zero-extended to 16 bits. rb_data_i is sampled in the cmd_valid_o cycle. Bits 23:16 keep the command and address just received.
- R7: sdo_oe_o rises after a readback command is issued. It stays high through the next frame and drops on that frame's chip select rise. It is low at all other times.
- R8: Any other command code (for example 3 or 11) leaves the register content unchanged when issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low chip select, asynchronous |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output bit |
| sdo_oe_o | output | 1 | Serial output drive enable |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 4 | Command code |
| addr_o | output | 4 | Channel/register address |
| data_o | output | 16 | Frame data bytes 1 and 0 |
| rb_data_i | input | 10 | Readback value from executor, valid in strobe cycle |

## Verification
The strobe must appear exactly three system cycles after chip select rises: two synchroniser stages plus the strobe register. The bench drives inputs on falling system edges and scans eight cycles after each rise, so it can check the count of strobes, their cycle position and the fields they carry. A shifted bit reaches sdo_o three system cycles after its serial edge. The bench therefore samples sdo_o four cycles after the serial clock falls, just before the next rise, and compares it with a register model that it keeps itself. That model applies the readback overlay one cycle after the strobe. sdo_oe_o is sampled before the first bit of a frame and after the strobe window, where both values are settled.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned RB_W   = 10;

  localparam logic [CMD_W-1:0] CMD_RB_STORED = 4'h9;
  localparam logic [CMD_W-1:0] CMD_RB_WIPER  = 4'hA;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
  parameter int unsigned FRAME_BITS = 24,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RB_W       = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_rise_i,
  input  logic                  csn_i,
  input  logic                  cs_fall_i,
  input  logic                  sdi_i,
  input  logic                  load_i,
  input  logic [RB_W-1:0]       load_data_i,
  output logic [FRAME_BITS-1:0] shreg_o,
  output logic                  full_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic                  take_bit;

  assign take_bit = sclk_rise_i && !csn_i;

  // saturates one past a full frame so long frames stay invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (cs_fall_i)                      cnt_q <= '0;
    else if (take_bit && cnt_q != CNT_OVER)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shreg_q <= '0;
    else if (load_i)   shreg_q[DATA_W-1:0] <= {{(DATA_W-RB_W){1'b0}}, load_data_i};
    else if (take_bit) shreg_q <= {shreg_q[FRAME_BITS-2:0], sdi_i};
  end

  assign shreg_o = shreg_q;
  assign full_o  = (cnt_q == CNT_FULL);

  AST_HOLD_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && !load_i) |=> $stable(shreg_q)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER); // R4
  AST_RB_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (shreg_q[DATA_W-1:RB_W] == '0)); // R6
endmodule

// File: rtl/spi_cmd_issue.sv
module spi_cmd_issue
  import spi_cmd_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_rise_i,
  input  logic                  full_i,
  input  logic [FRAME_BITS-1:0] shreg_i,
  output logic                  cmd_valid_o,
  output logic [CMD_W-1:0]      cmd_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_W-1:0]     data_o,
  output logic                  load_o,
  output logic                  sdo_oe_o
);
  localparam int unsigned CMD_LSB  = FRAME_BITS - CMD_W;
  localparam int unsigned ADDR_LSB = CMD_LSB - ADDR_W;

  logic valid_q, oe_q, is_rb;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= cs_rise_i && full_i;
      if (cs_rise_i && full_i) begin
        cmd_q  <= shreg_i[FRAME_BITS-1:CMD_LSB];
        addr_q <= shreg_i[CMD_LSB-1:ADDR_LSB];
        data_q <= shreg_i[DATA_W-1:0];
      end
    end
  end

  assign is_rb  = (cmd_q == CMD_RB_STORED) || (cmd_q == CMD_RB_WIPER);
  assign load_o = valid_q && is_rb;

  // output drive lasts for the frame that carries the readback out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_q <= 1'b0;
    else if (cs_rise_i) oe_q <= 1'b0;
    else if (load_o)    oe_q <= 1'b1;
  end

  assign cmd_valid_o = valid_q;
  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign sdo_oe_o    = oe_q;

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R3
  AST_STROBE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(full_i)); // R4
  AST_OE_FROM_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(load_o)); // R7
  AST_OE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !sdo_oe_o); // R7
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  input  logic [RB_W-1:0]   rb_data_i
);
  localparam int unsigned FRAME_BITS = CMD_W + ADDR_W + DATA_W;

  logic [2:0] sync_q;
  logic sclk_s, csn_s, sdi_s, sclk_d, csn_d;
  logic sclk_rise, cs_rise, cs_fall, full, load;
  logic [FRAME_BITS-1:0] shreg;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, csn_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {sclk_s, csn_s, sdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign cs_rise   = csn_s && !csn_d;
  assign cs_fall   = !csn_s && csn_d;

  spi_frame_shift #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W), .RB_W(RB_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(sclk_rise),
    .csn_i      (csn_s),
    .cs_fall_i  (cs_fall),
    .sdi_i      (sdi_s),
    .load_i     (load),
    .load_data_i(rb_data_i),
    .shreg_o    (shreg),
    .full_o     (full)
  );

  spi_cmd_issue #(.FRAME_BITS(FRAME_BITS)) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_rise_i  (cs_rise),
    .full_i     (full),
    .shreg_i    (shreg),
    .cmd_valid_o(cmd_valid_o),
    .cmd_o      (cmd_o),
    .addr_o     (addr_o),
    .data_o     (data_o),
    .load_o     (load),
    .sdo_oe_o   (sdo_oe_o)
  );

  assign sdo_o = shreg[FRAME_BITS-1];

  AST_NO_STROBE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csn_s && !csn_d) |=> !cmd_valid_o); // R3
endmodule

// File: tb/sim_spi_cmd_frontend.sv
module sim_spi_cmd_frontend;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, cmd_valid;
  logic [3:0] cmd, addr;
  logic [15:0] data;
  logic [9:0] rb_data = '0;

  int checks = 0, fails = 0;
  logic [23:0] model = '0;
  bit rb_pend = 0;

  always #10 clk = ~clk;

  spi_cmd_frontend u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cmd_valid_o(cmd_valid),
    .cmd_o(cmd), .addr_o(addr), .data_o(data), .rb_data_i(rb_data)
  );

  typedef struct packed {
    logic [31:0] word;
    logic [7:0]  nbits;
    logic [9:0]  rb;
    logic        exp_strobe;
  } vec_t;

  localparam vec_t [0:8] VEC = {
    vec_t'{32'h00B10155, 8'd24, 10'h000, 1'b1},
    vec_t'{32'h0090FFFF, 8'd24, 10'h2A5, 1'b1},
    vec_t'{32'h00000000, 8'd24, 10'h111, 1'b1},
    vec_t'{32'h00A11234, 8'd24, 10'h3FF, 1'b1},
    vec_t'{32'h007FFFFF, 8'd23, 10'h000, 1'b0},
    vec_t'{32'h01ABCDEF, 8'd25, 10'h000, 1'b0},
    vec_t'{32'h00B0C3C3, 8'd24, 10'h0F0, 1'b1},
    vec_t'{32'h003100AA, 8'd24, 10'h155, 1'b1},
    vec_t'{32'h00800000, 8'd24, 10'h000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input vec_t v);
    logic [23:0] got = '0;
    logic [23:0] prev = model;
    int strobes = 0, lat = 0;
    logic [3:0] c = '0, a = '0;
    logic [15:0] d = '0;
    bit exp_rb;
    rb_data = v.rb;
    csn = 1'b0;
    tick(4);
    chk(sdo_oe == rb_pend, "R7 oe in frame", {31'd0, sdo_oe}, {31'd0, rb_pend});
    for (int k = v.nbits - 1; k >= 0; k--) begin
      sdi = v.word[k];
      tick(4);
      if (v.nbits - 1 - k < 24) got[23 - (v.nbits - 1 - k)] = sdo;
      sclk = 1'b1;
      model = {model[22:0], v.word[k]};
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    csn = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      tick(1);
      if (cmd_valid) begin
        strobes++;
        lat = i;
        c = cmd; a = addr; d = data;
      end
    end
    if (v.nbits >= 24)
      chk(got == prev, "R5 shift-out", {8'd0, got}, {8'd0, prev});
    chk(strobes == int'(v.exp_strobe), "R3/R4 strobe count", strobes, {31'd0, v.exp_strobe});
    if (v.exp_strobe) begin
      chk(lat == 3, "R3 strobe cycle", lat, 3);
      chk({c, a, d} == v.word[23:0], "R3 fields", {8'd0, c, a, d}, {8'd0, v.word[23:0]});
    end
    exp_rb = v.exp_strobe && (v.word[23:20] == 4'h9 || v.word[23:20] == 4'hA);
    if (exp_rb) model[15:0] = {6'd0, v.rb};   // R6 overlay; R8 otherwise unchanged
    rb_pend = exp_rb;
    chk(sdo_oe == rb_pend, "R7 oe after frame", {31'd0, sdo_oe}, {31'd0, rb_pend});
    chk(sdo == model[23], "R5 sdo msb idle", {31'd0, sdo}, {31'd0, model[23]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk(cmd_valid == 1'b0, "R1 valid", {31'd0, cmd_valid}, 0);
    chk(sdo_oe == 1'b0, "R1 oe", {31'd0, sdo_oe}, 0);
    chk(sdo == 1'b0, "R1 sdo", {31'd0, sdo}, 0);
    rst_n = 1'b1;
    tick(4);

    for (int i = 0; i < 9; i++) run_frame(VEC[i]);

    // R2: serial clocks with chip select high shift nothing
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    chk(sdo == model[23], "R2 idle clocks sdo", {31'd0, sdo}, {31'd0, model[23]});
    run_frame(vec_t'{32'h00A05555, 8'd24, 10'h001, 1'b1}); // shift-out must still match model

    // R6 with zero readback value, then R8 with code 11 after it
    run_frame(vec_t'{32'h0091FFFF, 8'd24, 10'h000, 1'b1});
    run_frame(vec_t'{32'h00B1FFFF, 8'd24, 10'h3FF, 1'b1});
    run_frame(vec_t'{32'h00000000, 8'd24, 10'h000, 1'b1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule